// File: doc/BRIEF.md
# Word-to-Byte Infrared Transmit Frame Finisher

This block sits between a 32-bit transmit FIFO and the byte input of an infrared frame encoder. It pulls whole words from the FIFO and hands every byte of each word, least significant first, to the encoder over a valid/ready byte channel. Each byte carries a kind tag that marks it as payload, checksum or end flag. When the FIFO runs dry, the block either closes the frame or reports an error.

Frames whose length is not a multiple of four keep their last one to three bytes in a tail register. Software writes the tail word once to one of three aliased offsets, and the offset gives the number of valid bytes. When the FIFO is empty and the policy allows the frame to end, the tail bytes go out first. A 16-bit checksum follows, then an end flag. With the strict policy selected, an empty FIFO in the middle of a frame aborts it and raises a sticky underrun status instead. Software clears that policy once the last word of a frame is queued, so that the frame ends cleanly.

Top module: `irtx_frame_finisher`

## Requirements
- R1: Each FIFO word is emitted as four bytes in the order bits [7:0], [15:8], [23:16], [31:24]. Each of these bytes carries kind code 0 (data), and no zero padding is added.
- R2: A write at offset 0x14, 0x18 or 0x1C loads the tail with 1, 2 or 3 valid bytes, taken from bits [7:0], then [15:8], then [23:16]. These bytes are sent as data (kind 0) after the FIFO is found empty and before the checksum.
- R3: The checksum uses polynomial x^16+x^12+x^5+1, processed bit by bit least significant bit first (reflected constant 0x8408). Its preset is 0xFFFF and the result is complemented. It covers every data and tail byte and is sent low byte first with kind code 1. For the payload "123456789" the two checksum bytes are 0x6E, then 0x90.
- R4: After the checksum the block sends one end flag byte 0x7E with kind code 2 and then returns to idle. The tail count is cleared once the tail has been sent, so the following frame carries no tail unless a new one is written.
- R5: With the policy bit (bit 1 at offset 0x00) at 0, an empty FIFO at a word boundary ends the frame normally with tail, checksum and flag.
- R6: With the policy bit at 1, an empty FIFO at a word boundary sets the underrun status and aborts the frame. No checksum and no flag are sent.
- R7: The underrun status is sticky. Writing 1 to bit 0 at offset 0x04 clears it. If an underrun and that clearing write fall in the same cycle, the underrun wins.
- R8: A new frame starts only while the enable bit (bit 0 at offset 0x00) is 1 and the FIFO holds a word. While the bit is 0 and no frame is in flight, the FIFO is not read and no byte is offered.
- R9: While out_valid is high and out_ready is low, out_valid, out_byte and out_kind hold steady.
- R10: After reset, out_valid, fifo_ready and underrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register byte offset |
| wr_data | input | 32 | Register write data |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_data | input | 32 | FIFO head word |
| fifo_ready | output | 1 | Pop the FIFO head on this cycle if valid |
| out_valid | output | 1 | A byte is offered to the encoder |
| out_byte | output | 8 | Offered byte |
| out_kind | output | 2 | Byte kind: 0 data, 1 checksum, 2 end flag |
| out_ready | input | 1 | Encoder accepts the offered byte |
| underrun | output | 1 | Sticky transmit underrun status |

## Verification
The set of the underrun status by the sequencer and the software's clearing write can land in the same clock edge. The bench feeds a single word in strict mode and waits for the cycle in which the block asks for the next word with the FIFO empty. In that exact cycle it presents the write-1-to-clear, then checks that the status reads 1 afterwards and that no checksum byte followed. A second, isolated clearing write must then bring the status back to 0.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int IDX_W      = $clog2(WORD_BYTES);
    localparam int TAIL_W     = WORD_W - 8;
    localparam int TCNT_W     = IDX_W;
    localparam int ADDR_W     = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TAIL1 = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_TAIL2 = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_TAIL3 = 5'h1C;

    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_CRC  = 2'd1,
        KIND_END  = 2'd2
    } byte_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEND,
        ST_TAIL,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_FLAG
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
    } seq_t;

    typedef struct packed {
        logic              en;
        logic              strict;
        logic [TAIL_W-1:0] tail;
        logic [TCNT_W-1:0] cnt;
        logic              urun;
    } regs_t;

    // One byte through the reflected CRC-16 register.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/irtx_regs.sv
module irtx_regs
    import irtx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    tail_done,
    input  logic                    underrun_set,
    output logic                    ctrl_en,
    output logic                    ctrl_strict,
    output logic [TAIL_W-1:0]       tail_data,
    output logic [TCNT_W-1:0]       tail_cnt,
    output logic                    underrun
);

    regs_t r_d, r_q;
    logic  unused_hi;

    assign unused_hi = ^wr_data[WORD_W-1:TAIL_W];

    always_comb begin
        r_d = r_q;
        // Consumption first, so that a tail write in the same cycle survives.
        if (tail_done) begin
            r_d.cnt = '0;
        end
        if (wr_en) begin
            case (wr_addr)
                OFS_CTRL: begin
                    r_d.en     = wr_data[0];
                    r_d.strict = wr_data[1];
                end
                OFS_STAT: begin
                    if (wr_data[0]) begin
                        r_d.urun = 1'b0;
                    end
                end
                OFS_TAIL1: begin
                    r_d.tail = wr_data[TAIL_W-1:0];
                    r_d.cnt  = TCNT_W'(1);
                end
                OFS_TAIL2: begin
                    r_d.tail = wr_data[TAIL_W-1:0];
                    r_d.cnt  = TCNT_W'(2);
                end
                OFS_TAIL3: begin
                    r_d.tail = wr_data[TAIL_W-1:0];
                    r_d.cnt  = TCNT_W'(3);
                end
                default: ;
            endcase
        end
        // A fresh underrun overrides a clearing write in the same cycle.
        if (underrun_set) begin
            r_d.urun = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{en: 1'b0, strict: 1'b0, tail: '0, cnt: '0, urun: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_en     = r_q.en;
    assign ctrl_strict = r_q.strict;
    assign tail_data   = r_q.tail;
    assign tail_cnt    = r_q.cnt;
    assign underrun    = r_q.urun;

endmodule

// File: rtl/irtx_crc.sv
module irtx_crc
    import irtx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        crc_init,
    input  logic        crc_upd,
    input  logic [7:0]  byte_in,
    output logic [15:0] crc_val
);

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (crc_init) begin
            crc_d = CRC_PRESET;
        end else if (crc_upd) begin
            crc_d = crc_step(crc_q, byte_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_val = crc_q;

endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
    import irtx_pkg::*;
#(
    parameter logic [7:0] FLAG_BYTE = 8'h7E
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctrl_en,
    input  logic                    ctrl_strict,
    input  logic [TAIL_W-1:0]       tail_data,
    input  logic [TCNT_W-1:0]       tail_cnt,
    input  logic                    fifo_valid,
    input  logic [WORD_W-1:0]       fifo_data,
    output logic                    fifo_ready,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic [7:0]              out_byte,
    output logic [1:0]              out_kind,
    input  logic [15:0]             crc_val,
    output logic                    crc_init,
    output logic                    crc_upd,
    output logic                    tail_done,
    output logic                    underrun_set
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    seq_t              s_d, s_q;
    logic [WORD_W-1:0] tail_ext;
    logic [7:0]        word_byte;
    logic [7:0]        tail_byte;

    assign tail_ext  = {{(WORD_W-TAIL_W){1'b0}}, tail_data};
    assign word_byte = s_q.word[s_q.idx*8 +: 8];
    assign tail_byte = tail_ext[s_q.idx*8 +: 8];

    always_comb begin
        s_d          = s_q;
        fifo_ready   = 1'b0;
        out_valid    = 1'b0;
        out_byte     = 8'h00;
        out_kind     = KIND_DATA;
        crc_init     = 1'b0;
        crc_upd      = 1'b0;
        tail_done    = 1'b0;
        underrun_set = 1'b0;

        case (s_q.state)
            ST_IDLE: begin
                fifo_ready = ctrl_en;
                if (ctrl_en && fifo_valid) begin
                    s_d.word  = fifo_data;
                    s_d.idx   = '0;
                    s_d.state = ST_SEND;
                    crc_init  = 1'b1;
                end
            end
            ST_LOAD: begin
                fifo_ready = 1'b1;
                if (fifo_valid) begin
                    s_d.word  = fifo_data;
                    s_d.idx   = '0;
                    s_d.state = ST_SEND;
                end else if (ctrl_strict) begin
                    underrun_set = 1'b1;
                    s_d.state    = ST_IDLE;
                end else if (tail_cnt != '0) begin
                    s_d.idx   = '0;
                    s_d.state = ST_TAIL;
                end else begin
                    s_d.state = ST_CRC_LO;
                end
            end
            ST_SEND: begin
                out_valid = 1'b1;
                out_byte  = word_byte;
                out_kind  = KIND_DATA;
                if (out_ready) begin
                    crc_upd = 1'b1;
                    if (s_q.idx == LAST_IDX) begin
                        s_d.state = ST_LOAD;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                out_valid = 1'b1;
                out_byte  = tail_byte;
                out_kind  = KIND_DATA;
                if (out_ready) begin
                    crc_upd = 1'b1;
                    if (s_q.idx == (tail_cnt - 1'b1)) begin
                        tail_done = 1'b1;
                        s_d.state = ST_CRC_LO;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            ST_CRC_LO: begin
                out_valid = 1'b1;
                out_byte  = ~crc_val[7:0];
                out_kind  = KIND_CRC;
                if (out_ready) begin
                    s_d.state = ST_CRC_HI;
                end
            end
            ST_CRC_HI: begin
                out_valid = 1'b1;
                out_byte  = ~crc_val[15:8];
                out_kind  = KIND_CRC;
                if (out_ready) begin
                    s_d.state = ST_FLAG;
                end
            end
            ST_FLAG: begin
                out_valid = 1'b1;
                out_byte  = FLAG_BYTE;
                out_kind  = KIND_END;
                if (out_ready) begin
                    s_d.state = ST_IDLE;
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, idx: '0, word: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/irtx_frame_finisher.sv
module irtx_frame_finisher
    import irtx_pkg::*;
#(
    parameter logic [7:0] FLAG_BYTE = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              fifo_valid,
    input  logic [31:0]       fifo_data,
    output logic              fifo_ready,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic [1:0]        out_kind,
    input  logic              out_ready,
    output logic              underrun
);

    logic              ctrl_en;
    logic              ctrl_strict;
    logic [TAIL_W-1:0] tail_data;
    logic [TCNT_W-1:0] tail_cnt;
    logic              tail_done;
    logic              underrun_set;
    logic              crc_init;
    logic              crc_upd;
    logic [15:0]       crc_val;

    irtx_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .tail_done    (tail_done),
        .underrun_set (underrun_set),
        .ctrl_en      (ctrl_en),
        .ctrl_strict  (ctrl_strict),
        .tail_data    (tail_data),
        .tail_cnt     (tail_cnt),
        .underrun     (underrun)
    );

    irtx_crc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .crc_init (crc_init),
        .crc_upd  (crc_upd),
        .byte_in  (out_byte),
        .crc_val  (crc_val)
    );

    irtx_seq #(
        .FLAG_BYTE (FLAG_BYTE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_en      (ctrl_en),
        .ctrl_strict  (ctrl_strict),
        .tail_data    (tail_data),
        .tail_cnt     (tail_cnt),
        .fifo_valid   (fifo_valid),
        .fifo_data    (fifo_data),
        .fifo_ready   (fifo_ready),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_byte     (out_byte),
        .out_kind     (out_kind),
        .crc_val      (crc_val),
        .crc_init     (crc_init),
        .crc_upd      (crc_upd),
        .tail_done    (tail_done),
        .underrun_set (underrun_set)
    );

endmodule

// File: rtl/irtx_frame_finisher_chk.sv
module irtx_frame_finisher_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [4:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        fifo_ready,
    input logic        out_valid,
    input logic [7:0]  out_byte,
    input logic [1:0]  out_kind,
    input logic        out_ready,
    input logic        underrun,
    input logic        ctrl_en,
    input logic        ctrl_strict
);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_kind)));

    assert_flag_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd2) |-> (out_byte == 8'h7E));

    assert_kind_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_kind != 2'd3));

    assert_fetch_no_emit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ready |-> !out_valid);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !(wr_en && wr_addr == 5'h04 && wr_data[0])) |=> underrun);

    assert_abort_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> !out_valid);

    assert_underrun_needs_policy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(ctrl_strict));

    assert_disabled_stays_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !out_valid && !fifo_ready) |=> !out_valid);

endmodule

bind irtx_frame_finisher irtx_frame_finisher_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .fifo_ready  (fifo_ready),
    .out_valid   (out_valid),
    .out_byte    (out_byte),
    .out_kind    (out_kind),
    .out_ready   (out_ready),
    .underrun    (underrun),
    .ctrl_en     (ctrl_en),
    .ctrl_strict (ctrl_strict)
);

// File: tb/irtx_frame_finisher_test.sv
`timescale 1ns/1ps
module irtx_frame_finisher_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        fifo_valid;
    logic [31:0] fifo_data;
    logic        fifo_ready;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic [1:0]  out_kind;
    logic        out_ready = 1'b1;
    logic        underrun;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irtx_frame_finisher uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fifo_valid (fifo_valid),
        .fifo_data  (fifo_data),
        .fifo_ready (fifo_ready),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .out_kind   (out_kind),
        .out_ready  (out_ready),
        .underrun   (underrun)
    );

    // FIFO model
    logic [31:0] fmem [0:63];
    logic [5:0]  fwr = '0;
    logic [5:0]  frd = '0;
    assign fifo_valid = (frd != fwr);
    assign fifo_data  = fmem[frd];
    always @(posedge clk) begin
        if (rst_n && fifo_valid && fifo_ready) frd <= frd + 6'd1;
    end

    // Output log and hold monitor
    logic [7:0] lb [0:1023];
    logic [1:0] lk [0:1023];
    int         lcnt = 0;
    logic       stall_prev = 1'b0;
    logic [7:0] pb = '0;
    logic [1:0] pk = '0;
    int         hold_bad = 0;
    int         stalls = 0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                lb[lcnt] <= out_byte;
                lk[lcnt] <= out_kind;
                lcnt     <= lcnt + 1;
            end
            if (stall_prev && (!out_valid || out_byte != pb || out_kind != pk)) hold_bad++;
            if (out_valid && !out_ready) stalls++;
            stall_prev <= out_valid && !out_ready;
            pb <= out_byte;
            pk <= out_kind;
        end
    end

    // Backpressure driver
    bit bp_mode = 1'b0;
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        out_ready <= bp_mode ? ((cyc % 3) != 1) : 1'b1;
    end

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
            $finish;
        end
    end

    // Expectation model
    logic [7:0] eb [0:63];
    logic [1:0] ek [0:63];
    int         ecnt;

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ b[i];
            r  = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build_exp(input logic [31:0] w [8], input int nw,
                             input logic [31:0] tail, input int tc);
        logic [15:0] c;
        c = 16'hFFFF;
        ecnt = 0;
        for (int i = 0; i < nw; i++) begin
            for (int k = 0; k < 4; k++) begin
                eb[ecnt] = w[i][8*k +: 8];
                ek[ecnt] = 2'd0;
                c = ref_crc(c, eb[ecnt]);
                ecnt++;
            end
        end
        for (int k = 0; k < tc; k++) begin
            eb[ecnt] = tail[8*k +: 8];
            ek[ecnt] = 2'd0;
            c = ref_crc(c, eb[ecnt]);
            ecnt++;
        end
        c = ~c;
        eb[ecnt] = c[7:0];  ek[ecnt] = 2'd1; ecnt++;
        eb[ecnt] = c[15:8]; ek[ecnt] = 2'd1; ecnt++;
        eb[ecnt] = 8'h7E;   ek[ecnt] = 2'd2; ecnt++;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        fmem[fwr] = w;
        fwr = fwr + 6'd1;
    endtask

    task automatic wait_bytes(input int target, input int limit);
        int n;
        n = 0;
        while (lcnt < target && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic compare_log(input int base, input string req);
        check(lcnt - base == ecnt, req, "byte count", lcnt - base, ecnt);
        for (int i = 0; i < ecnt; i++) begin
            check(lb[base+i] == eb[i], req, $sformatf("byte %0d", i), lb[base+i], eb[i]);
            check(lk[base+i] == ek[i], req, $sformatf("kind %0d", i), lk[base+i], ek[i]);
        end
        check(out_valid == 1'b0, "R4", "idle after flag", out_valid, 0);
    endtask

    task automatic run_frame(input logic [31:0] w [8], input int nw,
                             input logic [31:0] tail, input int tc, input string req);
        int base;
        build_exp(w, nw, tail, tc);
        if (tc > 0) wr(5'(16 + 4 * tc), tail);
        else @(negedge clk);
        base = lcnt;
        for (int i = 0; i < nw; i++) push(w[i]);
        wait_bytes(base + ecnt, 600);
        repeat (6) @(negedge clk);
        compare_log(base, req);
    endtask

    // Scenarios
    task automatic t_reset();
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        check(fifo_ready == 1'b0, "R10", "fifo_ready after reset", fifo_ready, 0);
        check(underrun == 1'b0, "R10", "underrun after reset", underrun, 0);
    endtask

    task automatic t_known_answer();
        logic [31:0] w [8];
        w = '{32'h34333231, 32'h38373635, 0, 0, 0, 0, 0, 0};
        wr(5'h00, 32'h1);
        run_frame(w, 2, 32'h00000039, 1, "R3");
        check(lb[lcnt-3] == 8'h6E, "R3", "known answer low", lb[lcnt-3], 8'h6E);
        check(lb[lcnt-2] == 8'h90, "R3", "known answer high", lb[lcnt-2], 8'h90);
    endtask

    task automatic t_tails();
        logic [31:0] w [8];
        w = '{32'hA1B2C3D4, 32'h01020304, 32'hFFEE0011, 0, 0, 0, 0, 0};
        run_frame(w, 3, 32'h00C0FFEE, 2, "R2");
        w = '{32'h5A5AA5A5, 0, 0, 0, 0, 0, 0, 0};
        run_frame(w, 1, 32'h00123456, 3, "R2");
    endtask

    task automatic t_no_tail();
        logic [31:0] w [8];
        // Tail count was consumed by the previous frame: none expected here.
        w = '{32'hDEADBEEF, 32'h00000000, 0, 0, 0, 0, 0, 0};
        run_frame(w, 2, 32'h0, 0, "R4");
        w = '{32'h11223344, 0, 0, 0, 0, 0, 0, 0};
        run_frame(w, 1, 32'h0, 0, "R1");
    endtask

    task automatic t_backpressure();
        logic [31:0] w [8];
        int hb0;
        hb0 = hold_bad;
        bp_mode = 1'b1;
        w = '{32'h87654321, 32'h0F1E2D3C, 0, 0, 0, 0, 0, 0};
        run_frame(w, 2, 32'h00ABCDEF, 3, "R9");
        bp_mode = 1'b0;
        check(hold_bad == hb0, "R9", "byte held under stall", hold_bad - hb0, 0);
        check(stalls > 0, "R9", "stalls observed", stalls, 1);
    endtask

    task automatic t_enable_gate();
        logic [31:0] w [8];
        logic [5:0]  rd0;
        int          base;
        w = '{32'hCAFEF00D, 0, 0, 0, 0, 0, 0, 0};
        wr(5'h00, 32'h0);
        base = lcnt;
        rd0 = frd;
        push(w[0]);
        repeat (20) @(negedge clk);
        check(lcnt == base, "R8", "no bytes while disabled", lcnt - base, 0);
        check(frd == rd0, "R8", "FIFO untouched while disabled", frd, rd0);
        check(fifo_ready == 1'b0, "R8", "fifo_ready while disabled", fifo_ready, 0);
        build_exp(w, 1, 32'h0, 0);
        wr(5'h00, 32'h1);
        wait_bytes(base + ecnt, 600);
        repeat (6) @(negedge clk);
        compare_log(base, "R8");
    endtask

    task automatic t_underrun();
        int base;
        wr(5'h00, 32'h3);
        base = lcnt;
        push(32'h76543210);
        wait_bytes(base + 4, 200);
        repeat (10) @(negedge clk);
        check(underrun == 1'b1, "R6", "underrun raised", underrun, 1);
        check(lcnt == base + 4, "R6", "no checksum after abort", lcnt - base, 4);
        check(out_valid == 1'b0, "R6", "idle after abort", out_valid, 0);
        repeat (10) @(negedge clk);
        check(underrun == 1'b1, "R7", "underrun sticky", underrun, 1);
        wr(5'h04, 32'h1);
        check(underrun == 1'b0, "R7", "underrun cleared", underrun, 0);
    endtask

    task automatic t_strict_clean_end();
        logic [31:0] w [8];
        int base;
        w = '{32'h10203040, 32'h50607080, 32'h90A0B0C0, 0, 0, 0, 0, 0};
        build_exp(w, 3, 32'h0, 0);
        wr(5'h00, 32'h3);
        base = lcnt;
        for (int i = 0; i < 3; i++) push(w[i]);
        while (frd != fwr) @(negedge clk);
        wr(5'h00, 32'h1);
        wait_bytes(base + ecnt, 600);
        repeat (6) @(negedge clk);
        compare_log(base, "R5");
        check(underrun == 1'b0, "R5", "no underrun on clean end", underrun, 0);
    endtask

    task automatic t_collide();
        int base;
        int n;
        wr(5'h00, 32'h3);
        base = lcnt;
        push(32'h0BADCAFE);
        n = 0;
        while (!out_valid && n < 100) begin @(negedge clk); n++; end
        while (!fifo_ready && n < 200) begin @(negedge clk); n++; end
        wr_en = 1'b1; wr_addr = 5'h04; wr_data = 32'h1;
        @(negedge clk);
        wr_en = 1'b0;
        check(underrun == 1'b1, "R7", "set wins over same-cycle clear", underrun, 1);
        repeat (4) @(negedge clk);
        check(lcnt == base + 4, "R6", "no checksum after collided abort", lcnt - base, 4);
        wr(5'h04, 32'h1);
        check(underrun == 1'b0, "R7", "later clear takes effect", underrun, 0);
        wr(5'h00, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known_answer();
        t_tails();
        t_no_tail();
        t_backpressure();
        t_enable_gate();
        t_underrun();
        t_strict_clean_end();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule